// File: doc/BRIEF.md
# Prescaled match timer counter

A 16-bit up-counter fed by an 8-bit prescaler, with three compare channels that act on the count. The counter advances on qualifying events: every clock in the plain timer mode, or chosen edges of one external input in the event-counting modes. The prescaler divides those events by `prescale + 1` before the main count moves.

Each compare channel watches for the count equal to its compare value at the moment the count would step. On a hit the channel always emits a one-cycle pulse. It can also, by its own enable bits, set a sticky flag, restart the count from zero, or halt counting and drop the run state. Flags stay set until a clear bit is written for them. A synchronous clear request zeroes the count and the prescaler without touching the run state.

Top module: `pmt_timer`

## Requirements
- R1: The count is 16 bits and wraps from 0xFFFF to 0. The prescale counter runs from 0 up to `prescale`, then returns to 0. The count steps once on each such return, so it moves every `prescale + 1` qualifying events.
- R2: While `run` is 0, the count and the prescale counter hold their values.
- R3: With `cnt_clr` high at a clock edge, the count and the prescale counter are 0 after that edge. This overrides counting and suppresses compare hits in that cycle.
- R4: `mode` selects the qualifying event. 0 is every clock. 1 is a rising edge of `cap_in`, 2 a falling edge and 3 either edge. `cap_in` passes through two synchronizer flops, and an edge is a change between successive synchronized samples.
- R5: A hit on channel i occurs when the prescaler wraps while running, `cnt_clr` is low and the count equals compare value i. Channel i occupies bits `[16*i+15:16*i]` of `match_val`. `match_pulse[i]` is high for exactly the cycle after a hit.
- R6: A hit on channel i with `irq_en[i]` set makes `flags[i]` 1 from the next cycle on. The flag stays 1 until it is cleared.
- R7: A hit with `rst_en[i]` set loads the count with 0 instead of count + 1.
- R8: A hit with `stop_en[i]` set leaves the count at the hit value and clears `run`. When stop and restart hits coincide, stop wins.
- R9: A 1 in `flag_clr[i]` clears `flags[i]` at the next edge, and a 0 leaves the flag unchanged. A set and a clear in the same cycle leave the flag at 1.
- R10: `ctrl_wr` high loads `run` from `ctrl_en` at the next edge. A stop hit in the same cycle takes priority and leaves `run` at 0.
- R11: `rst` high at an edge clears the count, the prescale counter, `run`, all flags, all pulses and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | External event input, asynchronous |
| ctrl_wr | input | 1 | Load strobe for the run state |
| ctrl_en | input | 1 | Run value loaded by `ctrl_wr` |
| cnt_clr | input | 1 | Synchronous clear of count and prescaler |
| mode | input | 2 | Event source select: 0 clock, 1 rise, 2 fall, 3 both |
| prescale | input | 8 | Prescaler terminal value |
| match_val | input | 48 | Three packed 16-bit compare values, channel 0 lowest |
| irq_en | input | 3 | Per-channel flag-set enable |
| rst_en | input | 3 | Per-channel restart-on-hit enable |
| stop_en | input | 3 | Per-channel stop-on-hit enable |
| flag_clr | input | 3 | Per-channel flag clear, write 1 to clear |
| run | output | 1 | Current run state |
| count | output | 16 | Timer count |
| match_pulse | output | 3 | One-cycle hit pulse per channel |
| flags | output | 3 | Sticky per-channel flags |

## Verification
Two pairs of actions can land on the same edge: a flag set with its own clear, and a stop hit with a restart hit (or with a software run load). The bench holds `flag_clr` high across a whole compare period so that a hit falls inside the clear window. It also gives two channels the same compare value, one stopping and one restarting, and holds `ctrl_wr` high while stop hits keep recurring. A behavioural model compares the outputs every cycle and expects the flag to stay set, the count to freeze at the hit value and `run` to drop.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } src_mode_e;
endpackage

// File: rtl/pmt_event_src.sv
module pmt_event_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_in,
  input  pmt_pkg::src_mode_e  mode,
  output logic                ev
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (mode)
      pmt_pkg::SRC_CLK:  ev = 1'b1;
      pmt_pkg::SRC_RISE: ev = cur & ~prev_q;
      pmt_pkg::SRC_FALL: ev = ~cur & prev_q;
      default:           ev = cur ^ prev_q;
    endcase
  end
endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [PW-1:0] limit,
  output logic          tick
);
  logic [PW-1:0] pc_q;

  assign tick = adv && (pc_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc_q <= '0;
    end else if (adv) begin
      pc_q <= tick ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmt_match_unit.sv
module pmt_match_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] match_val,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          hit,
  output logic          pulse,
  output logic          flag
);
  assign hit = fire && (count == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= hit;
      flag  <= (flag & ~flag_clr) | (hit & irq_en);
    end
  end
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer #(
  parameter int CW          = 16,
  parameter int PW          = 8,
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_in,
  input  logic               ctrl_wr,
  input  logic               ctrl_en,
  input  logic               cnt_clr,
  input  logic [1:0]         mode,
  input  logic [PW-1:0]      prescale,
  input  logic [NCH*CW-1:0]  match_val,
  input  logic [NCH-1:0]     irq_en,
  input  logic [NCH-1:0]     rst_en,
  input  logic [NCH-1:0]     stop_en,
  input  logic [NCH-1:0]     flag_clr,
  output logic               run,
  output logic [CW-1:0]      count,
  output logic [NCH-1:0]     match_pulse,
  output logic [NCH-1:0]     flags
);
  logic           ev;
  logic           tick;
  logic           fire;
  logic [NCH-1:0] hit_v;
  logic           any_stop;
  logic           any_rst;

  pmt_event_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk    (clk),
    .rst    (rst),
    .cap_in (cap_in),
    .mode   (pmt_pkg::src_mode_e'(mode)),
    .ev     (ev)
  );

  pmt_prescaler #(.PW(PW)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .adv   (run && ev),
    .limit (prescale),
    .tick  (tick)
  );

  assign fire = tick && !cnt_clr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pmt_match_unit #(.CW(CW)) u_mu (
      .clk       (clk),
      .rst       (rst),
      .fire      (fire),
      .count     (count),
      .match_val (match_val[g*CW +: CW]),
      .irq_en    (irq_en[g]),
      .flag_clr  (flag_clr[g]),
      .hit       (hit_v[g]),
      .pulse     (match_pulse[g]),
      .flag      (flags[g])
    );
  end

  assign any_stop = |(hit_v & stop_en);
  assign any_rst  = |(hit_v & rst_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      run   <= 1'b0;
    end else begin
      if (cnt_clr)       count <= '0;
      else if (any_stop) count <= count;
      else if (any_rst)  count <= '0;
      else if (tick)     count <= count + 1'b1;

      if (any_stop)      run <= 1'b0;
      else if (ctrl_wr)  run <= ctrl_en;
    end
  end
endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_clr,
  input logic              run,
  input logic [CW-1:0]     count,
  input logic [NCH*CW-1:0] match_val,
  input logic [NCH-1:0]    match_pulse,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    flag_clr,
  input logic [NCH-1:0]    stop_en
);
  assert_clr_zero_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (count == '0));

  assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_clr) |=> $stable(count));

  assert_stop_drops_run_R8: assert property (@(posedge clk) disable iff (rst)
    (|(match_pulse & $past(stop_en))) |-> !run);

  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~$past(flags) & ~match_pulse) == '0));

  assert_flag_fall_R9: assert property (@(posedge clk) disable iff (rst)
    ((~flags & $past(flags) & ~$past(flag_clr)) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_pulse_equal_R5: assert property (@(posedge clk) disable iff (rst)
      match_pulse[g] |-> ($past(count) == $past(match_val[g*CW +: CW])));
  end
endmodule

bind pmt_timer pmt_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_clr     (cnt_clr),
  .run         (run),
  .count       (count),
  .match_val   (match_val),
  .match_pulse (match_pulse),
  .flags       (flags),
  .flag_clr    (flag_clr),
  .stop_en     (stop_en)
);

// File: tb/pmt_timer_test.sv
`timescale 1ns/1ps
module pmt_timer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_in = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic        ctrl_en = 1'b0;
  logic        cnt_clr = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  prescale = 8'd0;
  logic [47:0] match_val = '0;
  logic [2:0]  irq_en = '0, rst_en = '0, stop_en = '0, flag_clr = '0;
  logic        run;
  logic [15:0] count;
  logic [2:0]  match_pulse, flags;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R11";
  bit    done = 0;

  always #(PERIOD/2) clk = ~clk;

  pmt_timer uut (
    .clk(clk), .rst(rst), .cap_in(cap_in), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .cnt_clr(cnt_clr), .mode(mode), .prescale(prescale), .match_val(match_val),
    .irq_en(irq_en), .rst_en(rst_en), .stop_en(stop_en), .flag_clr(flag_clr),
    .run(run), .count(count), .match_pulse(match_pulse), .flags(flags)
  );

  function automatic void chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endfunction

  // behavioural reference
  int unsigned m_count = 0, m_pc = 0;
  bit          m_run = 0;
  bit [2:0]    m_flags = 0, m_pulse = 0;
  bit          hist[$];

  always @(posedge clk) begin
    bit ev, adv, tick, fire, stp, rs, cur, prv;
    bit [2:0] hit;
    if (rst) begin
      m_count = 0; m_pc = 0; m_run = 0; m_flags = 0; m_pulse = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      cur = hist[1];
      prv = hist[0];
      case (mode)
        2'd0:    ev = 1;
        2'd1:    ev = cur && !prv;
        2'd2:    ev = !cur && prv;
        default: ev = cur != prv;
      endcase
      adv  = m_run && ev;
      tick = adv && (m_pc == prescale);
      fire = tick && !cnt_clr;
      for (int i = 0; i < 3; i++)
        hit[i] = fire && (m_count == match_val[i*16 +: 16]);
      stp = |(hit & stop_en);
      rs  = |(hit & rst_en);
      m_flags = (m_flags & ~flag_clr) | (hit & irq_en);
      m_pulse = hit;
      if (cnt_clr) m_pc = 0;
      else if (adv) m_pc = tick ? 0 : (m_pc + 1) % 256;
      if (cnt_clr) m_count = 0;
      else if (stp) m_count = m_count;
      else if (rs) m_count = 0;
      else if (tick) m_count = (m_count + 1) % 65536;
      if (stp) m_run = 0;
      else if (ctrl_wr) m_run = ctrl_en;
      hist.push_back(cap_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "count", int'(count), int'(m_count));
      chk(cur_req, "run", int'(run), int'(m_run));
      chk(cur_req, "match_pulse", int'(match_pulse), int'(m_pulse));
      chk(cur_req, "flags", int'(flags), int'(m_flags));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    cnt_clr = 1'b1; cyc(1); cnt_clr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog run did not finish");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R11 reset state
    chk("R11", "count after reset", int'(count), 0);
    chk("R11", "run after reset", int'(run), 0);
    chk("R11", "flags after reset", int'(flags), 0);
    chk("R11", "pulse after reset", int'(match_pulse), 0);

    // R1 prescale by 3 in clock mode
    cur_req = "R1";
    prescale = 8'd2; mode = 2'd0;
    ctrl_en = 1'b1; ctrl_wr = 1'b1; cyc(1); ctrl_wr = 1'b0;
    cyc(15);
    chk("R1", "count after 15 clocks at prescale 2", int'(count), 5);

    // R2 disable freezes
    cur_req = "R2";
    ctrl_en = 1'b0; ctrl_wr = 1'b1; cyc(1); ctrl_wr = 1'b0;
    cyc(10);
    chk("R2", "count frozen", int'(count), 5);
    chk("R2", "run low", int'(run), 0);

    // R3 synchronous clear while running
    cur_req = "R3";
    ctrl_en = 1'b1; ctrl_wr = 1'b1; cyc(1); ctrl_wr = 1'b0;
    cyc(7);
    pulse_clr();
    chk("R3", "count after clear", int'(count), 0);
    cyc(8);

    // R1 wrap of the 16-bit count
    cur_req = "R1";
    prescale = 8'd0;
    pulse_clr();
    cyc(65540);

    // R4 edge-counting modes
    cur_req = "R4";
    for (int m = 1; m < 4; m++) begin
      mode = m[1:0];
      prescale = (m == 3) ? 8'd1 : 8'd0;
      pulse_clr();
      repeat (8) begin
        cap_in = ~cap_in;
        cyc(3);
      end
      cyc(4);
    end

    // R5 R6 R7 match with flag and restart
    cur_req = "R7";
    mode = 2'd0; prescale = 8'd0;
    match_val[15:0] = 16'd5;
    irq_en = 3'b001; rst_en = 3'b001;
    pulse_clr();
    cyc(20);
    chk("R6", "flag0 set after match", int'(flags[0]), 1);
    cur_req = "R5";
    cyc(6);

    // R9 clear, ineffective zero bits, set-over-clear
    cur_req = "R9";
    flag_clr = 3'b110; cyc(3);
    chk("R9", "flag0 kept by zero clear bit", int'(flags[0]), 1);
    flag_clr = 3'b001; cyc(1); flag_clr = 3'b000;
    cyc(3);
    flag_clr = 3'b001; cyc(14); flag_clr = 3'b000;
    cyc(8);

    // R8 stop over restart on coincident hits
    cur_req = "R8";
    irq_en = 3'b000; rst_en = 3'b100; stop_en = 3'b010;
    match_val[31:16] = 16'd7; match_val[47:32] = 16'd7;
    prescale = 8'd1;
    pulse_clr();
    cyc(25);
    chk("R8", "count held at stop value", int'(count), 7);
    chk("R8", "run cleared by stop", int'(run), 0);

    // R10 run load racing with recurring stop
    cur_req = "R10";
    prescale = 8'd0;
    ctrl_en = 1'b1; ctrl_wr = 1'b1; cyc(20); ctrl_wr = 1'b0;
    cyc(5);
    chk("R10", "count stays at stop value", int'(count), 7);

    done = 1;
    summary();
    $finish;
  end
endmodule